// File: doc/BRIEF.md
# Interlaced Vertical Timing Generator

This block produces the vertical blanking and vertical sync levels for a raster display. It also produces a field identifier and a frame-start pulse. A horizontal timing source outside the block supplies one strobe at the end of each line and one at the middle of each line. In progressive mode the vertical counter advances once per line. In interlaced mode it advances at every half line. Because of this, a frame with an odd number of lines splits into two fields of equal half-line length, and the second field begins in the middle of a line.

Software programs the blank and sync start/end positions through a small register port. The odd or progressive field has one set of positions and the even field has its own set. A shared register holds the vertical total and the active line count. Writes go into shadow copies. The copies move into the live set only at the next field or frame boundary after software has raised an update request, so a frame never runs on a half-written configuration.

Top module: `vt_timing`

## Requirements
- R1: After reset, vblank_o, vsync_o, frame_start_o, field_o and upd_pend_o are all 0.
- R2: The register map is as follows. Address 0 holds the vertical total in bits 26:16 and the active line count in bits 10:0. Address 1 holds the blank span and address 2 the sync span, both for odd or progressive fields. Address 3 holds the even-field blank span and address 4 the even-field sync span. Each span has its end in bits 26:16 and its start in bits 10:0. Address 5 is control: writing 1 to bit 0 requests an update, and reading bit 0 returns the pending flag. Bits 31:27 and 15:11 always read as 0.
- R3: A written value has no effect until the first field or frame boundary that follows an update request. At that boundary every shadow value is copied to the live set at once and the request clears.
- R4: upd_pend_o is 1 from the cycle after a request write until the boundary transfer.
- R5: In progressive mode (ilace_i=0) the counter advances only on eol_i. The counter wraps after it reaches the total. field_o is 0, and every wrap produces frame_start_o.
- R6: In interlaced mode the counter advances on both mid_i and eol_i, so one field lasts total+1 half lines. field_o toggles at each wrap. frame_start_o pulses only on a wrap into field 0.
- R7: A signal turns on at the tick where the counter equals its start comparison value and turns off at the tick where the counter equals its end comparison value. The end wins if both match. The comparison value is v in progressive mode and 2v+1 in interlaced mode, so the signal changes state on line v+1.
- R8: The even-field spans are used only while ilace_i=1 and field_o=1. In every other case the odd spans are used.
- R9: With an odd line count in interlaced mode, vsync rises on an end-of-line strobe in one field and on a mid-line strobe in the next.
- R10: vblank_o and vsync_o change only on the clock edge that consumes a counter tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eol_i | input | 1 | End-of-line strobe, one cycle |
| mid_i | input | 1 | Mid-line strobe, one cycle |
| ilace_i | input | 1 | 1 selects interlaced mode |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data (shadow values, pending flag) |
| vblank_o | output | 1 | Vertical blank level |
| vsync_o | output | 1 | Vertical sync level |
| field_o | output | 1 | Current field, 0 odd, 1 even |
| frame_start_o | output | 1 | One-cycle pulse at a frame start |
| upd_pend_o | output | 1 | Update request waiting for a boundary |

## Verification
Every output is registered. A strobe that is high in one cycle changes vblank_o, vsync_o, field_o or frame_start_o on the rising edge that ends that cycle, and upd_pend_o rises on the edge that takes the control write. The bench drives strobes and writes on falling edges and samples on the next falling edge. At that point it has counted exactly the ticks that the design has consumed. Each expected event is queued as the tick count at which it must first be seen, together with the strobe kind and field that it must show. The monitor pops an expected entry whenever a signal rises, and compares the two.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int unsigned POS_W  = 11;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TOTAL   = 3'd0,
    A_BLANK   = 3'd1,
    A_SYNC    = 3'd2,
    A_BLANK_E = 3'd3,
    A_SYNC_E  = 3'd4,
    A_CTRL    = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [POS_W-1:0] hi;
    logic [POS_W-1:0] lo;
  } span_t;

  typedef struct packed {
    span_t total;
    span_t blank;
    span_t sync;
    span_t blank_e;
    span_t sync_e;
  } shadow_t;

  typedef struct packed {
    logic [POS_W-1:0] total;
    span_t            blank;
    span_t            sync;
    span_t            blank_e;
    span_t            sync_e;
  } live_t;
endpackage

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              bound_i,
  output live_t             live_o,
  output logic              pend_o
);
  localparam int unsigned GAP_LO = HI_LSB - POS_W;
  localparam int unsigned GAP_HI = WORD_W - HI_LSB - POS_W;

  shadow_t shd_q;
  live_t   live_q;
  logic    req_q;
  span_t   wr_span;
  logic    req_wr;
  logic    unused_rsvd;

  assign wr_span     = '{hi: wr_data_i[HI_LSB +: POS_W], lo: wr_data_i[POS_W-1:0]};
  assign req_wr      = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[0];
  assign unused_rsvd = ^{wr_data_i[WORD_W-1:HI_LSB+POS_W], wr_data_i[HI_LSB-1:POS_W]};

  // shadow contents are undefined until written
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_TOTAL:   shd_q.total   <= wr_span;
        A_BLANK:   shd_q.blank   <= wr_span;
        A_SYNC:    shd_q.sync    <= wr_span;
        A_BLANK_E: shd_q.blank_e <= wr_span;
        A_SYNC_E:  shd_q.sync_e  <= wr_span;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (bound_i && req_q) begin
        live_q <= '{total:   shd_q.total.hi,
                    blank:   shd_q.blank,
                    sync:    shd_q.sync,
                    blank_e: shd_q.blank_e,
                    sync_e:  shd_q.sync_e};
        req_q  <= 1'b0;
      end
      if (req_wr) req_q <= 1'b1;  // a request on the boundary cycle waits for the next one
    end
  end

  function automatic logic [WORD_W-1:0] pack(span_t s);
    return {{GAP_HI{1'b0}}, s.hi, {GAP_LO{1'b0}}, s.lo};
  endfunction

  always_comb begin
    case (reg_addr_e'(rd_addr_i))
      A_TOTAL:   rd_data_o = pack(shd_q.total);
      A_BLANK:   rd_data_o = pack(shd_q.blank);
      A_SYNC:    rd_data_o = pack(shd_q.sync);
      A_BLANK_E: rd_data_o = pack(shd_q.blank_e);
      A_SYNC_E:  rd_data_o = pack(shd_q.sync_e);
      A_CTRL:    rd_data_o = {{(WORD_W-1){1'b0}}, req_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign live_o = live_q;
  assign pend_o = req_q;
endmodule

// File: rtl/vt_counter.sv
module vt_counter #(
  parameter int unsigned POS_W = 11,
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eol_i,
  input  logic             mid_i,
  input  logic             ilace_i,
  input  logic [POS_W-1:0] total_i,
  output logic             tick_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             field_o,
  output logic             frame_start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             field_q;
  logic             fs_q;

  assign tick_o = eol_i || (ilace_i && mid_i);
  assign wrap_o = tick_o && (cnt_q == {1'b0, total_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      field_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      if (tick_o) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      if (!ilace_i)    field_q <= 1'b0;
      else if (wrap_o) field_q <= ~field_q;
      // frame begins when entering the odd field, or at every wrap when progressive
      if (wrap_o) fs_q <= !ilace_i || field_q;
    end
  end

  assign cnt_o         = cnt_q;
  assign field_o       = field_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/vt_pulse.sv
module vt_pulse #(
  parameter int unsigned POS_W = 11,
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ilace_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] end_i,
  output logic             level_o
);
  logic [CNT_W-1:0] cmp_start, cmp_end;
  logic             lvl_q;

  // half-line units in interlaced mode: line v+1 begins after 2v+2 ticks
  assign cmp_start = ilace_i ? {start_i, 1'b1} : {1'b0, start_i};
  assign cmp_end   = ilace_i ? {end_i, 1'b1}   : {1'b0, end_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else if (tick_i) begin
      if (cnt_i == cmp_end)        lvl_q <= 1'b0;
      else if (cnt_i == cmp_start) lvl_q <= 1'b1;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/vt_timing.sv
module vt_timing
  import vt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eol_i,
  input  logic              mid_i,
  input  logic              ilace_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              vblank_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              frame_start_o,
  output logic              upd_pend_o
);
  localparam int unsigned CNT_W = POS_W + 1;
  localparam int unsigned N_SIG = 2;  // 0 blank, 1 sync

  live_t            live;
  logic             tick, wrap, use_even;
  logic [CNT_W-1:0] cnt;
  span_t            sel [N_SIG];
  logic [N_SIG-1:0] lvl;

  vt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .bound_i(wrap), .live_o(live), .pend_o(upd_pend_o)
  );

  vt_counter #(.POS_W(POS_W)) u_cnt (
    .clk_i, .rst_ni, .eol_i, .mid_i, .ilace_i,
    .total_i(live.total), .tick_o(tick), .wrap_o(wrap), .cnt_o(cnt),
    .field_o, .frame_start_o
  );

  assign use_even = ilace_i && field_o;
  assign sel[0]   = use_even ? live.blank_e : live.blank;
  assign sel[1]   = use_even ? live.sync_e  : live.sync;

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    vt_pulse #(.POS_W(POS_W)) u_pulse (
      .clk_i, .rst_ni, .tick_i(tick), .ilace_i, .cnt_i(cnt),
      .start_i(sel[g].lo), .end_i(sel[g].hi), .level_o(lvl[g])
    );
  end

  assign vblank_o = lvl[0];
  assign vsync_o  = lvl[1];
endmodule

// File: rtl/vt_chk.sv
module vt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eol_i,
  input logic       mid_i,
  input logic       ilace_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic       wr_req_bit_i,
  input logic       vblank_o,
  input logic       vsync_o,
  input logic       field_o,
  input logic       frame_start_o,
  input logic       upd_pend_o
);
  logic req_wr;
  assign req_wr = wr_en_i && (wr_addr_i == 3'd5) && wr_req_bit_i;

  // R6
  frame_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !field_o);

  // R5
  prog_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ilace_i) |-> !field_o);

  // R10
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(eol_i || (ilace_i && mid_i)) |-> $stable(vsync_o));

  // R10
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(eol_i || (ilace_i && mid_i)) |-> $stable(vblank_o));

  // R4
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_wr |=> upd_pend_o);

  // R3
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !$past(req_wr)) |-> !upd_pend_o);
endmodule

bind vt_timing vt_chk u_vt_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eol_i(eol_i), .mid_i(mid_i), .ilace_i(ilace_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_req_bit_i(wr_data_i[0]),
  .vblank_o(vblank_o), .vsync_o(vsync_o), .field_o(field_o),
  .frame_start_o(frame_start_o), .upd_pend_o(upd_pend_o)
);

// File: tb/vt_timing_tb_top.sv
module vt_timing_tb_top;
  typedef struct packed {
    logic [31:0] t;
    logic        m;
    logic        f;
  } ev_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        eol = 1'b0, mid = 1'b0, ilace = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        vblank, vsync, field, fstart, pend;

  int n_vec = 0, n_bad = 0;
  ev_t q_vsr[$], q_vsf[$], q_vbr[$], q_fs[$];
  bit          run = 1'b0, last_mid = 1'b0, prev_vs = 1'b0, prev_vb = 1'b0;
  int unsigned ticks = 0, ph = 7;

  localparam int FIELD_HL = 21;  // total field = 20, 21 lines per frame

  always #10 clk = ~clk;

  vt_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .eol_i(eol), .mid_i(mid), .ilace_i(ilace),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .vblank_o(vblank), .vsync_o(vsync), .field_o(field),
    .frame_start_o(fstart), .upd_pend_o(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  function automatic ev_t pop(inout ev_t q[$]);
    if (q.size() == 0) return '{t: 32'hFFFF_FFFF, m: 1'b0, f: 1'b0};
    return q.pop_front();
  endfunction

  // strobe driver and monitor: consume, compare, then drive the next cycle
  always @(negedge clk) begin
    ev_t e;
    if (run && (eol || (ilace && mid))) begin
      ticks++;
      last_mid = mid;
    end
    if (run) begin
      if (vsync && !prev_vs) begin
        e = pop(q_vsr);
        chk("R9 vsync rise tick", ticks, e.t);
        chk("R9 vsync rise on mid strobe", {31'b0, last_mid}, {31'b0, e.m});
        chk("R8 field at vsync rise", {31'b0, field}, {31'b0, e.f});
      end
      if (!vsync && prev_vs) begin
        e = pop(q_vsf);
        chk("R7 vsync fall tick", ticks, e.t);
      end
      if (vblank && !prev_vb) begin
        e = pop(q_vbr);
        chk("R8 vblank rise tick", ticks, e.t);
      end
      if (fstart) begin
        e = pop(q_fs);
        chk("R6 frame start tick", ticks, e.t);
        chk("R6 field at frame start", {31'b0, field}, 32'd0);
      end
    end
    prev_vs = vsync;
    prev_vb = vblank;
    if (run) begin
      ph  = (ph + 1) % 8;
      mid = (ph == 3);
      eol = (ph == 7);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 vblank", {31'b0, vblank}, 0);
    chk("R1 vsync", {31'b0, vsync}, 0);
    chk("R1 field", {31'b0, field}, 0);
    chk("R1 frame start", {31'b0, fstart}, 0);
    chk("R1 pending", {31'b0, pend}, 0);

    // R2 reserved bits read zero
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk("R2 blank reserved", 3'd1, 32'h07FF_07FF);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R2 total reserved", 3'd0, 32'h07FF_07FF);
    rd_chk("R2 control idle", 3'd5, 32'h0);

    // timing: total 20, active 8; odd blank 7..9, sync 2..3; even blank 6..9, sync 2..3
    wr(3'd0, (32'd20 << 16) | 32'd8);
    wr(3'd1, (32'd9 << 16) | 32'd7);
    wr(3'd2, (32'd3 << 16) | 32'd2);
    wr(3'd3, (32'd9 << 16) | 32'd6);
    wr(3'd4, (32'd3 << 16) | 32'd2);
    rd_chk("R2 even sync readback", 3'd4, 32'h0003_0002);
    wr(3'd5, 32'h1);
    chk("R4 pending after request", {31'b0, pend}, 1);
    rd_chk("R2 control pending bit", 3'd5, 32'h1);

    // progressive priming wrap (live total is 0): transfer happens here
    @(negedge clk); eol = 1'b1;
    @(negedge clk); eol = 1'b0;
    chk("R5 frame start on progressive wrap", {31'b0, fstart}, 1);
    chk("R5 field odd in progressive", {31'b0, field}, 0);
    chk("R3 request cleared at boundary", {31'b0, pend}, 0);

    // expected interlaced events; field 4 uses the sync span written mid-field 2 (R3)
    for (int f = 0; f < 5; f++) begin
      int s, en, bs, g;
      s  = (f == 4) ? 4 : 2;
      en = (f == 4) ? 5 : 3;
      bs = (f % 2) ? 6 : 7;
      g  = f * FIELD_HL + 2 * s + 1;
      q_vsr.push_back('{t: g + 1, m: (g % 2) == 0, f: f % 2});
      g  = f * FIELD_HL + 2 * en + 1;
      q_vsf.push_back('{t: g + 1, m: 1'b0, f: 1'b0});
      g  = f * FIELD_HL + 2 * bs + 1;
      q_vbr.push_back('{t: g + 1, m: 1'b0, f: 1'b0});
    end
    q_fs.push_back('{t: 32'd42, m: 1'b0, f: 1'b0});
    q_fs.push_back('{t: 32'd84, m: 1'b0, f: 1'b0});

    @(negedge clk);
    ilace = 1'b1;
    run   = 1'b1;

    wait (ticks >= 44);
    wr(3'd2, (32'd5 << 16) | 32'd4);
    wr(3'd5, 32'h1);
    chk("R4 pending mid-frame", {31'b0, pend}, 1);

    wait (ticks >= 105);
    @(negedge clk);
    run = 1'b0;
    mid = 1'b0;
    eol = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 request cleared after field boundary", {31'b0, pend}, 0);
    chk("R9 all vsync rises seen", q_vsr.size(), 0);
    chk("R7 all vsync falls seen", q_vsf.size(), 0);
    chk("R8 all vblank rises seen", q_vbr.size(), 0);
    chk("R6 all frame starts seen", q_fs.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule